// File: doc/BRIEF.md
# FSK Frequency Discriminator

This block sits at the head of an FSK receive chain. It converts a stream of complex baseband samples into a running estimate of instantaneous frequency. Each accepted sample is multiplied by the complex conjugate of the sample accepted just before it. The products are summed over a window of the last `OSR` products, which is one symbol period at the chosen oversampling ratio. The sum is then scaled down by an arithmetic right shift into a 16-bit signed range.

Later stages, such as preamble correlation or sign slicing, take the valid-qualified output. The imaginary part of the output grows with the frequency offset of the input tone: it is positive for counter-clockwise phase rotation and negative for clockwise rotation. Input samples arrive one per cycle at most, and each is marked by a valid strobe. Idle cycles may appear anywhere in the stream.

Top module: `fsk_freq_disc`

## Requirements
- R1: For each accepted sample z1 = a+jb whose previously accepted sample is z2 = c+jd, the product has real part a*c + b*d and imaginary part b*c - a*d. The first sample after reset only primes the history and yields no product.
- R2: The pre-scale value for a product is the exact sum of that product and the `OSR`-1 products before it.
- R3: Scaling is an arithmetic right shift of the window sum by `SHIFT` (default 3), which rounds toward minus infinity. For example, a window sum of -6 gives -1.
- R4: A shifted value above 32767 is output as 32767, and one below -32768 is output as -32768.
- R5: No output is produced until `OSR` products have been formed after reset, that is, until `OSR`+1 samples have been accepted. After that, every accepted sample yields exactly one output.
- R6: A sample accepted at clock edge t produces its output with `out_vld_o` high during the cycle after edge t+2. This latency is the same for every sample, whatever idle gaps occur in the stream.
- R7: While `in_vld_i` is low, the values on `in_re_i` and `in_im_i` have no effect. They are not used as history, and no output is produced for them.
- R8: While `rst_ni` is low, `out_vld_o` is 0 and both outputs are 0. The sample history and the window are cleared.
- R9: `OSR` may be set anywhere from 2 to 8 (default 6), and R2 through R5 hold for the chosen value.
- R10: For a constant-amplitude tone that advances 90 degrees per sample counter-clockwise, the imaginary output is positive. For the same tone turning clockwise, it is negative. With amplitude 100 and `OSR`=6, these values are +7500 and -7500.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Input sample strobe |
| in_re_i | input | IN_W (8) | Real part of the sample, signed |
| in_im_i | input | IN_W (8) | Imaginary part of the sample, signed |
| out_vld_o | output | 1 | Output strobe |
| out_re_o | output | OUT_W (16) | Scaled real part of the window sum, signed |
| out_im_o | output | OUT_W (16) | Scaled imaginary part of the window sum (frequency estimate), signed |

## Verification
Two instances, one with `OSR`=6 and one with `OSR`=8, take the same streams, and every output is compared with an arithmetic model. A long deterministic sweep of scattered 8-bit values catches sign or term errors in the conjugate product and window errors. Rotating tones in both directions separate the imaginary term from the real term and test the frequency sign. A stream with irregular gaps and random data on idle cycles distinguishes accepted samples from ignored ones and shows that latency does not change. Streams of constant full-scale negative samples and small alternating samples test saturation and the rounding direction of the shift, and a stream of exactly `OSR`, then `OSR`+1, samples tests when the first output appears.

// File: rtl/fsk_disc_pkg.sv
package fsk_disc_pkg;
  localparam int DEF_IN_W  = 8;
  localparam int DEF_OSR   = 6;
  localparam int DEF_SHIFT = 3;
  localparam int DEF_OUT_W = 16;

  // conjugate product of two IN_W-bit complex values, with headroom for a+b
  function automatic int prod_width(input int in_w);
    return 2 * in_w + 1;
  endfunction

  // window of osr products plus a guard bit
  function automatic int sum_width(input int in_w, input int osr);
    return prod_width(in_w) + $clog2(osr) + 1;
  endfunction
endpackage

// File: rtl/fdisc_conj_mult.sv
module fdisc_conj_mult #(
  parameter int IN_W   = 8,
  parameter int PROD_W = 17
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_vld_i,
  input  logic signed [IN_W-1:0]   in_re_i,
  input  logic signed [IN_W-1:0]   in_im_i,
  output logic                     prod_vld_o,
  output logic signed [PROD_W-1:0] prod_re_o,
  output logic signed [PROD_W-1:0] prod_im_o
);
  logic                   have_prev_q;
  logic signed [IN_W-1:0] prev_re_q, prev_im_q;
  logic signed [PROD_W-1:0] re_d, im_d;

  // z1 * conj(z2): re = ac + bd, im = bc - ad
  always_comb begin
    re_d = PROD_W'(in_re_i) * PROD_W'(prev_re_q) + PROD_W'(in_im_i) * PROD_W'(prev_im_q);
    im_d = PROD_W'(in_im_i) * PROD_W'(prev_re_q) - PROD_W'(in_re_i) * PROD_W'(prev_im_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      prev_re_q   <= '0;
      prev_im_q   <= '0;
      prod_vld_o  <= 1'b0;
      prod_re_o   <= '0;
      prod_im_o   <= '0;
    end else begin
      prod_vld_o <= in_vld_i && have_prev_q;
      if (in_vld_i) begin
        have_prev_q <= 1'b1;
        prev_re_q   <= in_re_i;
        prev_im_q   <= in_im_i;
        prod_re_o   <= re_d;
        prod_im_o   <= im_d;
      end
    end
  end
endmodule

// File: rtl/fdisc_movsum.sv
module fdisc_movsum #(
  parameter int OSR    = 6,
  parameter int PROD_W = 17,
  parameter int SUM_W  = 21
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     prod_vld_i,
  input  logic signed [PROD_W-1:0] prod_re_i,
  input  logic signed [PROD_W-1:0] prod_im_i,
  output logic                     sum_vld_o,
  output logic signed [SUM_W-1:0]  sum_re_o,
  output logic signed [SUM_W-1:0]  sum_im_o
);
  localparam int CNT_W = $clog2(OSR + 1);

  logic signed [PROD_W-1:0] dl_re_q [OSR];
  logic signed [PROD_W-1:0] dl_im_q [OSR];
  logic [CNT_W-1:0]         fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < OSR; i++) begin
        dl_re_q[i] <= '0;
        dl_im_q[i] <= '0;
      end
    end else if (prod_vld_i) begin
      dl_re_q[0] <= prod_re_i;
      dl_im_q[0] <= prod_im_i;
      for (int i = 1; i < OSR; i++) begin
        dl_re_q[i] <= dl_re_q[i-1];
        dl_im_q[i] <= dl_im_q[i-1];
      end
    end
  end

  // add the newest, drop the one leaving the window (zero while filling)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_re_o  <= '0;
      sum_im_o  <= '0;
      fill_q    <= '0;
      sum_vld_o <= 1'b0;
    end else begin
      sum_vld_o <= prod_vld_i && (fill_q >= CNT_W'(OSR - 1));
      if (prod_vld_i) begin
        sum_re_o <= sum_re_o + SUM_W'(prod_re_i) - SUM_W'(dl_re_q[OSR-1]);
        sum_im_o <= sum_im_o + SUM_W'(prod_im_i) - SUM_W'(dl_im_q[OSR-1]);
        if (fill_q != CNT_W'(OSR)) fill_q <= fill_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdisc_scale.sv
module fdisc_scale #(
  parameter int SUM_W = 21,
  parameter int OUT_W = 16,
  parameter int SHIFT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sum_vld_i,
  input  logic signed [SUM_W-1:0] sum_re_i,
  input  logic signed [SUM_W-1:0] sum_im_i,
  output logic                    out_vld_o,
  output logic signed [OUT_W-1:0] out_re_o,
  output logic signed [OUT_W-1:0] out_im_o
);
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] MIN_V = ~MAX_V;

  function automatic logic signed [OUT_W-1:0] shr_sat(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] s;
    s = v >>> SHIFT;
    if (s > MAX_V)      return OUT_W'(MAX_V);
    else if (s < MIN_V) return OUT_W'(MIN_V);
    else                return OUT_W'(s);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o <= 1'b0;
      out_re_o  <= '0;
      out_im_o  <= '0;
    end else begin
      out_vld_o <= sum_vld_i;
      if (sum_vld_i) begin
        out_re_o <= shr_sat(sum_re_i);
        out_im_o <= shr_sat(sum_im_i);
      end
    end
  end
endmodule

// File: rtl/fsk_freq_disc.sv
module fsk_freq_disc
  import fsk_disc_pkg::*;
#(
  parameter int IN_W  = DEF_IN_W,
  parameter int OSR   = DEF_OSR,
  parameter int SHIFT = DEF_SHIFT,
  parameter int OUT_W = DEF_OUT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_vld_i,
  input  logic signed [IN_W-1:0]  in_re_i,
  input  logic signed [IN_W-1:0]  in_im_i,
  output logic                    out_vld_o,
  output logic signed [OUT_W-1:0] out_re_o,
  output logic signed [OUT_W-1:0] out_im_o
);
  localparam int PROD_W = prod_width(IN_W);
  localparam int SUM_W  = sum_width(IN_W, OSR);

  logic                    prod_vld;
  logic signed [PROD_W-1:0] prod_re, prod_im;
  logic                    sum_vld;
  logic signed [SUM_W-1:0] sum_re, sum_im;

  fdisc_conj_mult #(.IN_W(IN_W), .PROD_W(PROD_W)) u_mult (
    .clk_i, .rst_ni, .in_vld_i, .in_re_i, .in_im_i,
    .prod_vld_o(prod_vld), .prod_re_o(prod_re), .prod_im_o(prod_im)
  );

  fdisc_movsum #(.OSR(OSR), .PROD_W(PROD_W), .SUM_W(SUM_W)) u_sum (
    .clk_i, .rst_ni,
    .prod_vld_i(prod_vld), .prod_re_i(prod_re), .prod_im_i(prod_im),
    .sum_vld_o(sum_vld), .sum_re_o(sum_re), .sum_im_o(sum_im)
  );

  fdisc_scale #(.SUM_W(SUM_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_scale (
    .clk_i, .rst_ni,
    .sum_vld_i(sum_vld), .sum_re_i(sum_re), .sum_im_i(sum_im),
    .out_vld_o, .out_re_o, .out_im_o
  );
endmodule

// File: rtl/fsk_freq_disc_chk.sv
module fsk_freq_disc_chk #(
  parameter int OSR   = 6,
  parameter int SHIFT = 3,
  parameter int OUT_W = 16,
  parameter int SUM_W = 21
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_vld_i,
  input logic                    prod_vld_i,
  input logic                    sum_vld_i,
  input logic signed [SUM_W-1:0] sum_re_i,
  input logic                    out_vld_o,
  input logic signed [OUT_W-1:0] out_re_o
);
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] MIN_V = ~MAX_V;
  localparam int SEEN_W = $clog2(OSR + 2) + 1;

  logic [SEEN_W-1:0]       seen_q;
  logic signed [SUM_W-1:0] shr;
  assign shr = sum_re_i >>> SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (in_vld_i && seen_q != SEEN_W'(OSR + 1)) seen_q <= seen_q + 1'b1;
  end

  // R8
  reset_idle_chk: assert property (@(posedge clk_i) !rst_ni |-> !out_vld_o);

  // R5
  fill_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> seen_q == SEEN_W'(OSR + 1));

  // R6
  fixed_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> $past(in_vld_i, 3));

  // R7
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_vld_i |=> !prod_vld_i);

  // R4
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_i && shr > MAX_V) |=> out_re_o == OUT_W'(MAX_V));

  // R3
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_vld_i && shr <= MAX_V && shr >= MIN_V) |=> out_re_o == $signed($past(shr[OUT_W-1:0])));
endmodule

bind fsk_freq_disc fsk_freq_disc_chk #(
  .OSR(OSR), .SHIFT(SHIFT), .OUT_W(OUT_W), .SUM_W(SUM_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_vld_i(in_vld_i),
  .prod_vld_i(prod_vld), .sum_vld_i(sum_vld), .sum_re_i(sum_re),
  .out_vld_o(out_vld_o), .out_re_o(out_re_o)
);

// File: tb/test_fsk_freq_disc.sv
module test_fsk_freq_disc;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_vld = 1'b0;
  logic signed [7:0] in_re = '0, in_im = '0;
  logic out_vld, out_vld8;
  logic signed [15:0] out_re, out_im, out_re8, out_im8;

  int checks = 0, failures = 0, cyc = 0;
  int s_re [8192];
  int s_im [8192];
  int drv_cyc [8192];
  int ns = 0, nout = 0, nout8 = 0;
  int last_re = 0, last_im = 0, last_re8 = 0, last_im8 = 0;
  logic mon_en = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  fsk_freq_disc i_fsk_freq_disc (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_re_i(in_re), .in_im_i(in_im),
    .out_vld_o(out_vld), .out_re_o(out_re), .out_im_o(out_im)
  );

  fsk_freq_disc #(.OSR(8)) i_fsk_freq_disc_o8 (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(in_vld), .in_re_i(in_re), .in_im_i(in_im),
    .out_vld_o(out_vld8), .out_re_o(out_re8), .out_im_o(out_im8)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model of R1..R4 for window ending at sample n
  function automatic int model(input int n, input int osr, input bit im);
    int acc = 0;
    for (int k = n - osr + 1; k <= n; k++) begin
      if (im) acc += s_im[k] * s_re[k-1] - s_re[k] * s_im[k-1];
      else    acc += s_re[k] * s_re[k-1] + s_im[k] * s_im[k-1];
    end
    acc = acc >>> 3;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  always @(negedge clk) begin
    if (mon_en && out_vld) begin
      int n;
      n = 6 + nout;
      chk(int'(out_re) == model(n, 6, 1'b0), "R1 R2 R3 R4 re osr6", int'(out_re), model(n, 6, 1'b0));
      chk(int'(out_im) == model(n, 6, 1'b1), "R1 R2 R3 R4 im osr6", int'(out_im), model(n, 6, 1'b1));
      chk(cyc == drv_cyc[n] + 3, "R6 latency osr6", cyc - drv_cyc[n], 3);
      last_re = int'(out_re);
      last_im = int'(out_im);
      nout++;
    end
    if (mon_en && out_vld8) begin
      int n;
      n = 8 + nout8;
      chk(int'(out_re8) == model(n, 8, 1'b0), "R9 R4 re osr8", int'(out_re8), model(n, 8, 1'b0));
      chk(int'(out_im8) == model(n, 8, 1'b1), "R9 im osr8", int'(out_im8), model(n, 8, 1'b1));
      chk(cyc == drv_cyc[n] + 3, "R6 latency osr8", cyc - drv_cyc[n], 3);
      last_re8 = int'(out_re8);
      last_im8 = int'(out_im8);
      nout8++;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    in_vld = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_vld == 1'b0 && out_vld8 == 1'b0, "R8 valid low in reset", int'(out_vld), 0);
    chk(out_re == 0 && out_im == 0, "R8 outputs zero in reset", int'(out_re) + int'(out_im), 0);
    ns = 0; nout = 0; nout8 = 0;
    rst_n = 1'b1;
    mon_en = 1'b1;
  endtask

  task automatic send(input int re, input int im);
    @(negedge clk);
    in_vld = 1'b1;
    in_re = 8'(re);
    in_im = 8'(im);
    s_re[ns] = re;
    s_im[ns] = im;
    drv_cyc[ns] = cyc;
    ns++;
  endtask

  // idle cycles carry junk data that must be ignored (R7)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      in_re = 8'($urandom);
      in_im = 8'($urandom);
    end
  endtask

  task automatic check_count(input string tag);
    idle(5);
    chk(nout == (ns > 6 ? ns - 6 : 0), tag, nout, ns > 6 ? ns - 6 : 0);
    chk(nout8 == (ns > 8 ? ns - 8 : 0), tag, nout8, ns > 8 ? ns - 8 : 0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2 rst_n = 1'b0;
    do_reset();

    // R5: exactly OSR samples give nothing, one more gives one output
    for (int i = 0; i < 6; i++) send(10 * i - 20, 7 - 3 * i);
    idle(5);
    chk(nout == 0, "R5 no output after OSR samples", nout, 0);
    send(33, -44);
    idle(5);
    chk(nout == 1, "R5 first output after OSR+1 samples", nout, 1);

    // R10: counter-clockwise quarter-turn tone
    do_reset();
    for (int i = 0; i < 20; i++) begin
      case (i % 4)
        0: send(100, 0);
        1: send(0, 100);
        2: send(-100, 0);
        default: send(0, -100);
      endcase
    end
    check_count("R5 count ccw");
    chk(last_im == 7500, "R10 ccw im positive", last_im, 7500);
    chk(last_re == 0, "R10 ccw re zero", last_re, 0);
    chk(last_im8 == 10000, "R10 ccw im osr8", last_im8, 10000);

    // R10: clockwise tone
    do_reset();
    for (int i = 0; i < 20; i++) begin
      case (i % 4)
        0: send(100, 0);
        1: send(0, -100);
        2: send(-100, 0);
        default: send(0, 100);
      endcase
    end
    check_count("R5 count cw");
    chk(last_im == -7500, "R10 cw im negative", last_im, -7500);

    // R1 R2: scattered value sweep, back to back
    do_reset();
    for (int i = 0; i < 3000; i++)
      send(((i * 37 + 11) % 256) - 128, ((i * 101 + 57) % 256) - 128);
    check_count("R5 count sweep");

    // R6 R7: irregular gaps with junk on idle cycles
    do_reset();
    for (int i = 0; i < 400; i++) begin
      send(((i * 53 + 5) % 256) - 128, ((i * 29 + 200) % 256) - 128);
      idle((i * 7) % 4);
    end
    check_count("R7 count gapped");

    // R4 R3: full-scale negative corner
    do_reset();
    for (int i = 0; i < 12; i++) send(-128, -128);
    check_count("R5 count sat");
    chk(last_re8 == 32767, "R4 saturate osr8", last_re8, 32767);
    chk(last_re == 24576, "R3 shift osr6", last_re, 24576);

    // R3: floor rounding of a small negative sum
    do_reset();
    for (int i = 0; i < 12; i++) send((i % 2) ? -1 : 1, 0);
    check_count("R5 count floor");
    chk(last_re == -1, "R3 floor osr6", last_re, -1);
    chk(last_re8 == -1, "R3 floor osr8", last_re8, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule